// File: doc/BRIEF.md
# Final Radix-2 Adder Butterfly Stage

This block is the closing stage of a pipelined decimation-in-frequency FFT. By this point the twiddle factor can only be +1 or -1, so the stage needs no multiplier. It takes one complex sample on each clock where `ce` is high. It groups those samples into neighbouring pairs: an even sample `x0` followed by the next sample `x1`. For each pair it produces two results, first `x0 + x1` and then `x0 - x1`.

A one-cycle pulse on `sync_in` marks the first sample of a frame. The stage tracks pair parity from that mark and keeps re-aligning to later marks. It raises `sync_out` together with the first sum that follows each mark, so the next stage can find the frame boundary. Each output component is one bit wider than its input, so no result can wrap.

The stream is paced by `ce` only and has no back-pressure. Every clock with `ce` high accepts one input and moves the output register one step. Clocks with `ce` low freeze all state. The consumer must take each output before the next `ce`.

Top module: `lastbf_adder`

## Requirements
- R1: While `rst` is high on a clock edge, the phase, the frame state and the output registers clear. After reset is released, `data_out` reads 0 and `sync_out` reads 0.
- R2: `data_in` carries the real part in bits [2*IW-1:IW] and the imaginary part in bits [IW-1:0], both two's complement. `data_out` uses the same layout with OW = IW+1 bits per part, the real part in bits [2*OW-1:OW].
- R3: Until the first `ce` clock on which `sync_in` is high, no pairing takes place. On every `ce` clock before then, the output register loads 0 and `sync_out` stays 0.
- R4: The sample taken on a `ce` clock with `sync_in` high is the even member `x0` of a pair. The sample on the next `ce` clock is its odd partner `x1`. After that, pairs follow back to back.
- R5: For a pair whose `x0` arrives on ce event k and `x1` on event k+1, the output register loads `x0 + x1` on event k+2.
- R6: On event k+3, the output register loads `x0 - x1`, with the earlier sample as the minuend.
- R7: `sync_out` is 1 only while the output holds the first sum after a `sync_in` mark. It is never 1 with a difference or with a zero fill. It can become 1 only at a `ce` clock.
- R8: On a clock with `ce` low, `data_out`, `sync_out` and all internal state keep their values. The results depend only on the sequence of `ce` samples, not on how those samples are spaced in time.
- R9: Extreme inputs give exact results: -2^(IW-1) + -2^(IW-1) yields -2^IW, and (2^(IW-1)-1) - (-2^(IW-1)) yields 2^IW-1.
- R10: A new `sync_in` mark on an odd position restarts pairing at that sample. The interrupted pair's sum is still emitted, and its difference is replaced by the new pair's sum, which carries `sync_out`.
- R11: Once the first pair has been taken, every `ce` clock yields a new output, and sums and differences alternate without any pause.
- R12: Before the first sum after a mark, the output register loads 0 when neither a sum nor a difference is due.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Sample strobe; advances the stage by one sample |
| sync_in | input | 1 | Marks the current input as the first sample of a frame |
| data_in | input | 2*IW | Complex input sample, real part in the upper half |
| data_out | output | 2*(IW+1) | Complex sum or difference, real part in the upper half |
| sync_out | output | 1 | High with the first sum of a frame |

## Verification
The bench drives the stage with dense, sparse and irregular `ce` patterns and checks that a stalled cycle changes nothing. A design that moved on a low `ce` would drift out of pair alignment and fail the very next comparison. It puts the most negative and most positive codes into both halves of a pair, which exposes a missing guard bit as a sign flip on the sum or the difference. It sends marks on odd positions to check the re-alignment priority and that `sync_out` never lands on a difference. It also drives traffic before any mark, which a design that paired samples too early would turn into non-zero output.

// File: rtl/lastbf_pkg.sv
package lastbf_pkg;

  // What the output register loads on a ce event
  typedef enum logic [1:0] {
    LD_ZERO = 2'd0,
    LD_SUM  = 2'd1,
    LD_DIFF = 2'd2
  } load_kind_e;

endpackage

// File: rtl/lastbf_phase.sv
module lastbf_phase (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic sync_in,
  output logic tag_even,
  output logic tag_sync
);

  logic started_q;
  logic odd_q;

  // Tag the sample entering on this clock
  assign tag_even = sync_in | (started_q & ~odd_q);
  assign tag_sync = sync_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      odd_q     <= 1'b0;
    end else if (ce) begin
      if (sync_in) begin
        started_q <= 1'b1;
        odd_q     <= 1'b1;
      end else if (started_q) begin
        odd_q <= ~odd_q;
      end else begin
        odd_q <= 1'b0;
      end
    end
  end

  // R3
  pre_sync_phase_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !started_q |-> !odd_q);

  // R4
  phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && started_q && !sync_in) |=> (odd_q != $past(odd_q)));

  // R10
  resync_align_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && sync_in) |=> (started_q && odd_q));

endmodule

// File: rtl/lastbf_delay.sv
module lastbf_delay #(
  parameter int W     = 24,
  parameter int DEPTH = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce,
  input  logic [W-1:0]       din,
  input  logic               even_in,
  input  logic               sync_in,
  output logic [DEPTH*W-1:0] dat_o,
  output logic [DEPTH-1:0]   even_o,
  output logic [DEPTH-1:0]   sync_o
);

  // Tap i holds the sample taken i+1 ce events ago
  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    logic [W-1:0] d_q;
    logic         e_q;
    logic         s_q;
    logic [W-1:0] d_src;
    logic         e_src;
    logic         s_src;

    if (i == 0) begin : g_head
      assign d_src = din;
      assign e_src = even_in;
      assign s_src = sync_in;
    end else begin : g_body
      assign d_src = g_tap[i-1].d_q;
      assign e_src = g_tap[i-1].e_q;
      assign s_src = g_tap[i-1].s_q;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        d_q <= '0;
        e_q <= 1'b0;
        s_q <= 1'b0;
      end else if (ce) begin
        d_q <= d_src;
        e_q <= e_src;
        s_q <= s_src;
      end
    end

    assign dat_o[i*W +: W] = d_q;
    assign even_o[i]       = e_q;
    assign sync_o[i]       = s_q;
  end

endmodule

// File: rtl/lastbf_bfly.sv
module lastbf_bfly
  import lastbf_pkg::*;
#(
  parameter int IW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [2*IW-1:0]   tap1,
  input  logic [2*IW-1:0]   tap2,
  input  logic [2*IW-1:0]   tap3,
  input  logic              even2,
  input  logic              even3,
  input  logic              sync2,
  output logic [2*IW+1:0]   data_out,
  output logic              sync_out
);

  localparam int OW = IW + 1;

  load_kind_e         kind;
  logic [2*OW-1:0]    sum_w;
  logic [2*OW-1:0]    diff_w;
  logic [2*OW-1:0]    out_q;
  logic               sync_q;

  // Sum has priority so a re-aligned pair is never delayed
  always_comb begin
    if (even2)      kind = LD_SUM;
    else if (even3) kind = LD_DIFF;
    else            kind = LD_ZERO;
  end

  // Component 1 is real (upper half), component 0 is imaginary
  for (genvar c = 0; c < 2; c++) begin : g_part
    logic signed [OW-1:0] a1;
    logic signed [OW-1:0] a2;
    logic signed [OW-1:0] a3;
    assign a1 = OW'($signed(tap1[c*IW +: IW]));
    assign a2 = OW'($signed(tap2[c*IW +: IW]));
    assign a3 = OW'($signed(tap3[c*IW +: IW]));
    assign sum_w[c*OW +: OW]  = a2 + a1;
    assign diff_w[c*OW +: OW] = a3 - a2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      sync_q <= 1'b0;
    end else if (ce) begin
      unique case (kind)
        LD_SUM: begin
          out_q  <= sum_w;
          sync_q <= sync2;
        end
        LD_DIFF: begin
          out_q  <= diff_w;
          sync_q <= 1'b0;
        end
        default: begin
          out_q  <= '0;
          sync_q <= 1'b0;
        end
      endcase
    end
  end

  assign data_out = out_q;
  assign sync_out = sync_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (data_out == '0 && !sync_out));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce && !$past(rst)) |=> ($stable(data_out) && $stable(sync_out)));

  // R7
  sync_not_diff_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && !even2 && even3) |=> !sync_out);

endmodule

// File: rtl/lastbf_adder.sv
module lastbf_adder #(
  parameter int IW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              sync_in,
  input  logic [2*IW-1:0]   data_in,
  output logic [2*IW+1:0]   data_out,
  output logic              sync_out
);

  localparam int W     = 2 * IW;
  localparam int DEPTH = 3;

  logic               tag_even;
  logic               tag_sync;
  logic [DEPTH*W-1:0] taps;
  logic [DEPTH-1:0]   evens;
  logic [DEPTH-1:0]   syncs;

  lastbf_phase u_phase (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .sync_in  (sync_in),
    .tag_even (tag_even),
    .tag_sync (tag_sync)
  );

  lastbf_delay #(.W(W), .DEPTH(DEPTH)) u_delay (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .din     (data_in),
    .even_in (tag_even),
    .sync_in (tag_sync),
    .dat_o   (taps),
    .even_o  (evens),
    .sync_o  (syncs)
  );

  lastbf_bfly #(.IW(IW)) u_bfly (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .tap1     (taps[0 +: W]),
    .tap2     (taps[W +: W]),
    .tap3     (taps[2*W +: W]),
    .even2    (evens[1]),
    .even3    (evens[2]),
    .sync2    (syncs[1]),
    .data_out (data_out),
    .sync_out (sync_out)
  );

  // R7
  sync_on_ce_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_out) |-> $past(ce));

endmodule

// File: tb/lastbf_adder_tb.sv
module lastbf_adder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int IW = 12;
  localparam int OW = IW + 1;
  localparam int VMAX = (1 << (IW - 1)) - 1;
  localparam int VMIN = -(1 << (IW - 1));

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ce = 1'b0;
  logic              sync_in = 1'b0;
  logic [2*IW-1:0]   data_in = '0;
  logic [2*OW-1:0]   data_out;
  logic              sync_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Behavioural history: index 0 newest
  int hre[3];
  int him[3];
  bit hev[3];
  bit hsy[3];
  bit started = 0;
  int since_sync = 0;
  int exp_re = 0;
  int exp_im = 0;
  bit exp_sy = 0;
  string exp_req = "R1";

  lastbf_adder #(.IW(IW)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .sync_in  (sync_in),
    .data_in  (data_in),
    .data_out (data_out),
    .sync_out (sync_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic compare(input string tag);
    int got_re;
    int got_im;
    got_re = int'($signed(data_out[2*OW-1:OW]));
    got_im = int'($signed(data_out[OW-1:0]));
    total++;
    if (got_re !== exp_re || got_im !== exp_im || sync_out !== exp_sy) begin
      bad++;
      $display("FAIL %s/%s: got re=%0d im=%0d sync=%0d expected re=%0d im=%0d sync=%0d",
               exp_req, tag, got_re, got_im, sync_out, exp_re, exp_im, exp_sy);
    end
  endtask

  // Drive one clock (called at a falling edge), model it, then check
  task automatic step(input bit c, input bit s, input int re, input int im, input string tag);
    bit ev;
    ce = c;
    sync_in = s;
    data_in = {IW'(re), IW'(im)};
    if (c) begin
      if (hev[1]) begin
        exp_re = hre[1] + hre[0];
        exp_im = him[1] + him[0];
        exp_sy = hsy[1];
        exp_req = exp_sy ? "R7" : "R5";
      end else if (hev[2]) begin
        exp_re = hre[2] - hre[1];
        exp_im = him[2] - him[1];
        exp_sy = 0;
        exp_req = "R6";
      end else begin
        exp_re = 0;
        exp_im = 0;
        exp_sy = 0;
        exp_req = started ? "R12" : "R3";
      end
      if (s) begin
        started = 1;
        since_sync = 0;
      end else if (started) begin
        since_sync++;
      end
      ev = started && (since_sync % 2 == 0);
      for (int i = 2; i > 0; i--) begin
        hre[i] = hre[i-1];
        him[i] = him[i-1];
        hev[i] = hev[i-1];
        hsy[i] = hsy[i-1];
      end
      hre[0] = re;
      him[0] = im;
      hev[0] = ev;
      hsy[0] = s;
    end else begin
      exp_req = "R8";
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      hre[i] = 0; him[i] = 0; hev[i] = 0; hsy[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    exp_req = "R1";
    compare("R1 reset state");

    // R3: traffic before any mark
    for (int i = 0; i < 6; i++) step(1, 0, 100 + i, -50 - i, "R3 no mark");

    // R2 R4 R5 R6 R7: dense frame with distinct real/imag parts
    step(1, 1, 10, -3, "R4 first pair");
    for (int i = 1; i < 10; i++) step(1, 0, 10 * i + 7, 3 - 5 * i, "R2 dense");

    // R8: sparse and irregular ce
    for (int i = 0; i < 24; i++)
      step((i % 3) == 0, 0, 31 * i - 200, 17 - 9 * i, "R8 sparse");
    step(1, 1, 400, 401, "R8 mark in gaps");
    for (int i = 0; i < 20; i++)
      step((i % 2) == 1, 0, -13 * i, 7 * i, "R8 alternate");

    // R9: extremes
    step(1, 1, VMIN, VMAX, "R9 x0");
    step(1, 0, VMIN, VMIN, "R9 x1");
    step(1, 0, VMAX, VMAX, "R9 x0b");
    step(1, 0, VMIN, VMIN, "R9 x1b");
    step(1, 0, 0, 0, "R9 sum");
    step(1, 0, 0, 0, "R9 diff");
    step(1, 0, 0, 0, "R9 sum2");
    step(1, 0, 0, 0, "R9 diff2");

    // R10: mark on an odd position
    step(1, 1, 5, 6, "R10 even");
    step(1, 1, 50, 60, "R10 odd mark");
    for (int i = 0; i < 6; i++) step(1, 0, i + 1, -i, "R10 after");

    // R11: long random run with random ce and rare marks
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step(r < 70, r == 3, int'($urandom_range(0, 4095)) + VMIN,
           int'($urandom_range(0, 4095)) + VMIN, "R11 random");
    end
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R11 drain");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule